// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the bus side of a byte-wide parallel flash device and interprets the write cycles the host issues. It samples the address and data at each rising edge of the write strobe and walks a sequence state machine through the unlock and command cycles. The result is one of three outcomes. It can stay in read-array mode, where the read bus passes the array's data through. It can enter identifier mode, where the read bus carries fixed identification and protection codes selected by the two lowest address bits. It can issue a one-cycle start pulse to a separate chip-erase engine.

A reset command, data F0h at any address, is always accepted. It returns the decoder to read-array mode. If the erase engine reports busy, it also pulses an abort line to that engine. While the engine is busy, every other write is ignored. A write that does not fit the expected sequence returns the decoder to read-array mode and starts nothing.

Sequence states, in the order of a full erase sequence: `SEQ_IDLE` (waiting for the first unlock), `SEQ_U1` (first unlock seen), `SEQ_U2` (second unlock seen, command expected), `SEQ_ES` (erase set-up seen), `SEQ_ES_U1`, `SEQ_ES_U2` (the unlocks after set-up).

Transitions:
- IDLE→U1 on 555h/AAh.
- U1→U2 on 2AAh/55h.
- U2→IDLE with identifier mode on 555h/90h.
- U2→ES on 555h/80h.
- ES→ES_U1 on 555h/AAh.
- ES_U1→ES_U2 on 2AAh/55h.
- ES_U2→IDLE with an erase start on 555h/10h.
- Any state→IDLE with read-array mode on F0h, or on any write that breaks the sequence.

Read modes are `MODE_ARRAY` and `MODE_ID`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read-array mode with `id_mode`, `erase_start` and `op_abort` low.
- R2: In read-array mode `rd_data` equals `array_rdata` for every address.
- R3: A write of data F0h at any address, in any state, returns the decoder to read-array mode. The decoder then stays there, with reads passing array data, until a later command changes the mode.
- R4: The writes 555h/AAh, 2AAh/55h, 555h/90h, in that order, enter identifier mode and set `id_mode` high.
- R5: In identifier mode the value of `rd_data` depends on `bus_addr[1:0]`. It is C2h for 00, the device code for 01, `{7'b0, region_prot}` for 10, and 00h for 11. The device code is 36h when `BOTTOM_BOOT`=0 and 37h when it is 1.
- R6: The six writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h raise `erase_start` for exactly one cycle. The pulse comes in the cycle after the clock edge that samples the final write strobe's rising edge. The decoder is then in read-array mode.
- R7: A write whose address or data differs from the expected pair at any position of a sequence returns the decoder to read-array mode and raises no `erase_start`.
- R8: While `erase_busy` is high, every write other than F0h leaves the mode and sequence state unchanged and raises no `erase_start`.
- R9: An F0h write accepted while `erase_busy` is high raises `op_abort` for one cycle. An F0h write while not busy does not.
- R10: A write counts only on a rising edge of `bus_we`. Holding `bus_we` high while changing address or data adds no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | CMD_ADDR_W | Low address bits seen by the decoder |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, sampled; its rising edge marks a write |
| array_rdata | input | 8 | Byte read from the memory array |
| region_prot | input | 1 | Protection status of the addressed region |
| erase_busy | input | 1 | Erase engine is running |
| rd_data | output | 8 | Read data towards the host |
| id_mode | output | 1 | High in identifier mode |
| erase_start | output | 1 | One-cycle chip-erase start pulse |
| op_abort | output | 1 | One-cycle abort pulse to the erase engine |

## Verification
The assertions check the following on every cycle:
- read-array pass-through and the manufacturer code in identifier mode;
- that state and mode change only on a strobe edge;
- that F0h always lands in the idle state and read-array mode;
- that busy freezes everything else;
- that start and abort are single-cycle pulses tied to the correct preceding state.

Only the bench scenarios can show that complete ordered sequences reach identifier mode or an erase start. The same holds for showing that a corruption at each position of the six-cycle sequence blocks the start, and for the device code chosen by the boot variant.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_U1    = 3'd1,
        SEQ_U2    = 3'd2,
        SEQ_ES    = 3'd3,
        SEQ_ES_U1 = 3'd4,
        SEQ_ES_U2 = 3'd5
    } seq_state_t;

    typedef enum logic {
        MODE_ARRAY = 1'b0,
        MODE_ID    = 1'b1
    } rd_mode_t;

    localparam int ADDR_KEY_A = 'h555;
    localparam int ADDR_KEY_B = 'h2AA;

    localparam logic [7:0] DAT_KEY_A   = 8'hAA;
    localparam logic [7:0] DAT_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;

    localparam logic [7:0] CODE_MFR     = 8'hC2;
    localparam logic [7:0] CODE_DEV_TOP = 8'h36;
    localparam logic [7:0] CODE_DEV_BOT = 8'h37;

endpackage

// File: rtl/wr_strobe_detect.sv
module wr_strobe_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic we_in,
    output logic we_rise
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b0;
        end else begin
            we_q <= we_in;
        end
    end

    assign we_rise = we_in && !we_q;
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int CMD_ADDR_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_fire,
    input  logic [CMD_ADDR_W-1:0] wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  busy,
    output seq_state_t            seq_state,
    output rd_mode_t              mode,
    output logic                  start_pulse,
    output logic                  abort_pulse
);
    localparam logic [CMD_ADDR_W-1:0] KEY_A = CMD_ADDR_W'(ADDR_KEY_A);
    localparam logic [CMD_ADDR_W-1:0] KEY_B = CMD_ADDR_W'(ADDR_KEY_B);

    seq_state_t seq_q, seq_d;
    rd_mode_t   mode_q, mode_d;
    logic       start_d, abort_d;
    logic       is_reset, at_a, at_b;

    assign is_reset = (wr_data == CMD_RESET);
    assign at_a     = (wr_addr == KEY_A);
    assign at_b     = (wr_addr == KEY_B);

    // next-state decode
    always_comb begin
        seq_d   = seq_q;
        mode_d  = mode_q;
        start_d = 1'b0;
        abort_d = 1'b0;
        if (wr_fire) begin
            if (is_reset) begin
                seq_d   = SEQ_IDLE;
                mode_d  = MODE_ARRAY;
                abort_d = busy;
            end else if (!busy) begin
                // default outcome of any write: sequence broken
                seq_d  = SEQ_IDLE;
                mode_d = MODE_ARRAY;
                unique case (seq_q)
                    SEQ_IDLE: begin
                        if (at_a && wr_data == DAT_KEY_A) begin
                            seq_d  = SEQ_U1;
                            mode_d = mode_q;
                        end
                    end
                    SEQ_U1: begin
                        if (at_b && wr_data == DAT_KEY_B) begin
                            seq_d  = SEQ_U2;
                            mode_d = mode_q;
                        end
                    end
                    SEQ_U2: begin
                        if (at_a && wr_data == CMD_IDENT) begin
                            seq_d  = SEQ_IDLE;
                            mode_d = MODE_ID;
                        end else if (at_a && wr_data == CMD_SETUP) begin
                            seq_d  = SEQ_ES;
                            mode_d = mode_q;
                        end
                    end
                    SEQ_ES: begin
                        if (at_a && wr_data == DAT_KEY_A) begin
                            seq_d  = SEQ_ES_U1;
                            mode_d = mode_q;
                        end
                    end
                    SEQ_ES_U1: begin
                        if (at_b && wr_data == DAT_KEY_B) begin
                            seq_d  = SEQ_ES_U2;
                            mode_d = mode_q;
                        end
                    end
                    SEQ_ES_U2: begin
                        if (at_a && wr_data == CMD_CHIP) begin
                            start_d = 1'b1;
                        end
                    end
                    default: begin
                        seq_d  = SEQ_IDLE;
                        mode_d = MODE_ARRAY;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= SEQ_IDLE;
            mode_q <= MODE_ARRAY;
        end else begin
            seq_q  <= seq_d;
            mode_q <= mode_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            start_pulse <= start_d;
            abort_pulse <= abort_d;
        end
    end

    assign seq_state = seq_q;
    assign mode      = mode_q;
endmodule

// File: rtl/id_read_mux.sv
module id_read_mux
    import flash_cmd_pkg::*;
#(
    parameter bit BOTTOM_BOOT = 1'b0
) (
    input  rd_mode_t   mode,
    input  logic [1:0] addr_lo,
    input  logic       prot,
    input  logic [7:0] array_rdata,
    output logic [7:0] rd_data
);
    logic [7:0] dev_code;
    logic [7:0] id_byte;

    generate
        if (BOTTOM_BOOT) begin : g_bottom
            assign dev_code = CODE_DEV_BOT;
        end else begin : g_top
            assign dev_code = CODE_DEV_TOP;
        end
    endgenerate

    always_comb begin
        unique case (addr_lo)
            2'b00:   id_byte = CODE_MFR;
            2'b01:   id_byte = dev_code;
            2'b10:   id_byte = {7'b0, prot};
            default: id_byte = 8'h00;
        endcase
    end

    assign rd_data = (mode == MODE_ID) ? id_byte : array_rdata;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int CMD_ADDR_W  = 11,
    parameter bit BOTTOM_BOOT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CMD_ADDR_W-1:0] bus_addr,
    input  logic [7:0]            bus_wdata,
    input  logic                  bus_we,
    input  logic [7:0]            array_rdata,
    input  logic                  region_prot,
    input  logic                  erase_busy,
    output logic [7:0]            rd_data,
    output logic                  id_mode,
    output logic                  erase_start,
    output logic                  op_abort
);
    logic       wr_fire;
    seq_state_t seq_q;
    rd_mode_t   mode_q;

    wr_strobe_detect u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_in   (bus_we),
        .we_rise (wr_fire)
    );

    cmd_seq_fsm #(
        .CMD_ADDR_W (CMD_ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .busy        (erase_busy),
        .seq_state   (seq_q),
        .mode        (mode_q),
        .start_pulse (erase_start),
        .abort_pulse (op_abort)
    );

    id_read_mux #(
        .BOTTOM_BOOT (BOTTOM_BOOT)
    ) u_mux (
        .mode        (mode_q),
        .addr_lo     (bus_addr[1:0]),
        .prot        (region_prot),
        .array_rdata (array_rdata),
        .rd_data     (rd_data)
    );

    assign id_mode = (mode_q == MODE_ID);
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       we_rise,
    input logic [7:0] wdata,
    input logic [1:0] addr_lo,
    input logic       busy,
    input seq_state_t seq_state,
    input rd_mode_t   mode,
    input logic [7:0] rd_data,
    input logic [7:0] array_rdata,
    input logic       erase_start,
    input logic       op_abort
);
    // R2
    array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ARRAY) |-> (rd_data == array_rdata));

    // R5
    mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ID && addr_lo == 2'b00) |-> (rd_data == 8'hC2));

    // R3
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && wdata == 8'hF0) |=> (mode == MODE_ARRAY && seq_state == SEQ_IDLE));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && busy && wdata != 8'hF0) |=> ($stable(mode) && $stable(seq_state) && !erase_start));

    // R10
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_rise |=> ($stable(mode) && $stable(seq_state)));

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R6
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> ($past(seq_state) == SEQ_ES_U2 && $past(wdata) == 8'h10
                         && mode == MODE_ARRAY && seq_state == SEQ_IDLE));

    // R9
    abort_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |-> ($past(busy) && $past(wdata) == 8'hF0));

    // R9
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |=> !op_abort);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_rise     (wr_fire),
    .wdata       (bus_wdata),
    .addr_lo     (bus_addr[1:0]),
    .busy        (erase_busy),
    .seq_state   (seq_q),
    .mode        (mode_q),
    .rd_data     (rd_data),
    .array_rdata (array_rdata),
    .erase_start (erase_start),
    .op_abort    (op_abort)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    array_rdata = 8'h00;
    logic          region_prot = 1'b0;
    logic          erase_busy = 1'b0;
    logic [7:0]    rd_data, rd_data_b;
    logic          id_mode, id_mode_b;
    logic          erase_start, erase_start_b;
    logic          op_abort, op_abort_b;

    int n_checks = 0;
    int n_fail   = 0;
    int starts   = 0;
    logic last_start, last_abort;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.CMD_ADDR_W(AW), .BOTTOM_BOOT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .array_rdata(array_rdata), .region_prot(region_prot),
        .erase_busy(erase_busy), .rd_data(rd_data), .id_mode(id_mode),
        .erase_start(erase_start), .op_abort(op_abort));

    flash_cmd_decoder #(.CMD_ADDR_W(AW), .BOTTOM_BOOT(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .array_rdata(array_rdata), .region_prot(region_prot),
        .erase_busy(erase_busy), .rd_data(rd_data_b), .id_mode(id_mode_b),
        .erase_start(erase_start_b), .op_abort(op_abort_b));

    always @(posedge clk) if (rst_n && erase_start) starts <= starts + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        last_start = erase_start;
        last_abort = op_abort;
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic enter_id();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] seq_a [6];
        logic [7:0]    seq_d [6];
        int s0;
        seq_a = '{11'h555, 11'h2AA, 11'h555, 11'h555, 11'h2AA, 11'h555};
        seq_d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!id_mode && !erase_start && !op_abort, "R1 reset", {id_mode, erase_start, op_abort}, 0);

        // R2 pass-through sweep
        for (int v = 0; v < 256; v += 17) begin
            array_rdata = 8'(v); bus_addr = 11'(v * 5);
            #1 chk(rd_data == 8'(v), "R2 array pass", rd_data, v);
        end

        // R4 entry
        enter_id();
        chk(id_mode && id_mode_b, "R4 id entry", {id_mode, id_mode_b}, 3);

        // R5 sweep over low bits, protection, upper bits
        for (int hi = 0; hi < 4; hi++) begin
            for (int lo = 0; lo < 4; lo++) begin
                for (int p = 0; p < 2; p++) begin
                    int e, eb;
                    bus_addr = 11'((hi * 'h155) << 2 | lo);
                    region_prot = p[0];
                    array_rdata = 8'h5A;
                    e  = (lo == 0) ? 'hC2 : (lo == 1) ? 'h36 : (lo == 2) ? p : 0;
                    eb = (lo == 1) ? 'h37 : e;
                    #1;
                    chk(rd_data == 8'(e), "R5 id read top", rd_data, e);
                    chk(rd_data_b == 8'(eb), "R5 id read bottom", rd_data_b, eb);
                end
            end
        end

        // R3 reset command, then stays in array mode
        wr(11'h123, 8'hF0);
        chk(!id_mode, "R3 F0 leaves id", id_mode, 0);
        for (int k = 0; k < 4; k++) begin
            array_rdata = 8'(8'h30 + k); bus_addr = 11'(k);
            @(negedge clk);
            chk(rd_data == 8'(8'h30 + k), "R3 stays array", rd_data, 8'h30 + k);
        end
        // R3 F0 mid-sequence
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hF0); wr(11'h555, 8'h90);
        chk(!id_mode, "R3 F0 mid-sequence", id_mode, 0);

        // R6 full erase sequence from id mode
        enter_id();
        s0 = starts;
        for (int i = 0; i < 6; i++) begin
            wr(seq_a[i], seq_d[i]);
            if (i < 5) chk(!last_start, "R6 no early start", last_start, 0);
        end
        chk(last_start, "R6 start timing", last_start, 1);
        chk(starts == s0 + 1, "R6 single pulse", starts - s0, 1);
        chk(!id_mode, "R6 array after erase", id_mode, 0);

        // R7 corruption at each position, data then address
        for (int kind = 0; kind < 2; kind++) begin
            for (int pos = 0; pos < 6; pos++) begin
                enter_id();
                s0 = starts;
                for (int i = 0; i <= pos; i++) begin
                    if (i == pos && kind == 0) wr(seq_a[i], seq_d[i] ^ 8'h01);
                    else if (i == pos) wr(seq_a[i] ^ 11'h004, seq_d[i]);
                    else wr(seq_a[i], seq_d[i]);
                end
                // finish remaining cycles: must not start from broken state
                for (int i = pos + 1; i < 6; i++) wr(seq_a[i], seq_d[i]);
                chk(starts == s0 && !id_mode, "R7 broken sequence", {starts - s0, id_mode}, 0);
            end
        end

        // R8 busy: commands ignored
        enter_id();
        erase_busy = 1'b1;
        s0 = starts;
        wr(11'h000, 8'h33);
        chk(id_mode, "R8 garbage ignored when busy", id_mode, 1);
        for (int i = 0; i < 6; i++) wr(seq_a[i], seq_d[i]);
        chk(starts == s0 && id_mode, "R8 erase ignored when busy", starts - s0, 0);

        // R9 abort while busy
        wr(11'h000, 8'hF0);
        chk(last_abort && !id_mode, "R9 abort when busy", {last_abort, id_mode}, 2);
        erase_busy = 1'b0;
        enter_id();
        chk(id_mode, "R8 commands resume", id_mode, 1);
        wr(11'h000, 8'hF0);
        chk(!last_abort, "R9 no abort when idle", last_abort, 0);

        // R10 held strobe counts once
        @(negedge clk);
        bus_addr = 11'h555; bus_wdata = 8'hAA; bus_we = 1'b1;
        repeat (3) @(negedge clk);
        bus_addr = 11'h2AA; bus_wdata = 8'h55;
        repeat (3) @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        wr(11'h555, 8'h90);
        chk(!id_mode, "R10 held strobe single write", id_mode, 0);
        @(negedge clk);
        bus_addr = 11'h555; bus_wdata = 8'hAA; bus_we = 1'b1;
        repeat (5) @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
        chk(id_mode, "R10 long strobe accepted", id_mode, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule